// File: doc/BRIEF.md
# Timer interrupt status and routing

This block collects fire events from a small set of comparator timers and turns them into activity on a bank of interrupt output lines. Each timer has its own enable, a trigger type (edge or level) and a route number that picks an output line. A global enable and a legacy-mode switch apply to every timer. Legacy mode replaces the route of the first two timers with fixed lines.

A level-type timer that fires sets its bit in an interrupt status register. Its routed line stays high until software clears the bit by writing a one to that position. An edge-type timer that fires leaves its status bit clear and drives its routed line for exactly one clock. A disarm strobe from the timer logic stops a timer and removes any interrupt it holds. The counter, the comparator arithmetic, the periodic reload and the bus decoding all live outside this block. The block only sees per-timer fire and disarm strobes, the configuration levels and a status-write strobe with its data.

Top module: `tirq_status_router`

## Requirements
- R1: Status bit n belongs to timer n. `sts_rdata` is 32 bits wide, bits at and above the timer count always read zero, and the whole register is zero after reset with every line low.
- R2: A fire on an armed level-type timer (`tmr_level` bit = 1) sets its status bit on the next clock. Its routed line is then held high for as long as the bit stays set.
- R3: A fire on an armed edge-type timer (`tmr_level` bit = 0) clears its status bit. Its routed line goes high for exactly the one cycle after the fire and is low again the cycle after.
- R4: A fire on a timer whose enable bit or `glb_enable` is low clears its status bit and produces no line activity.
- R5: A status write with `sts_wr` high clears each status bit whose `sts_wdata` bit is one, and this also deasserts that timer's line. Bits written as zero keep their value, and so do data bits at or above the timer count.
- R6: When a fire and a status-write clear hit the same timer in the same cycle, the fire is applied and the clear is dropped.
- R7: A disarm strobe clears the timer's status bit and deasserts its line on the next clock. It wins over a fire in the same cycle.
- R8: Routes are 5-bit fields, with timer n in `tmr_route[5n+4:5n]`. With `legacy_mode` high, timer 0 drives line 2 and timer 1 drives line 8. Timer 2 and above always use their field, and every timer uses its field when `legacy_mode` is low.
- R9: Each line is the OR of the held-level and one-cycle-pulse contributions of every timer routed to it.
- R10: With no fire, disarm or matching clear, a status bit keeps its value from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| glb_enable | input | 1 | Global interrupt enable |
| legacy_mode | input | 1 | Fixed routing for timers 0 and 1 |
| tmr_enable | input | 3 | Per-timer interrupt enable |
| tmr_level | input | 3 | Per-timer type: 1 level, 0 edge |
| tmr_route | input | 15 | Per-timer route, 5 bits per timer |
| fire | input | 3 | Per-timer fire strobe |
| disarm | input | 3 | Per-timer stop strobe |
| sts_wr | input | 1 | Status-register write strobe |
| sts_wdata | input | 32 | Write-one-to-clear data |
| sts_rdata | output | 32 | Status register readback |
| irq_lines | output | 32 | Interrupt output lines |

## Verification
The bench fires single timers of each type. This separates held level lines from one-cycle pulses, and it shows a level bit being set versus an edge fire leaving it clear. Status writes are tried with all-zero data, with a bit that does not match, with a matching bit and with all ones. These show that only ones in set positions have an effect. Fires are also issued with the timer enable low, with the global enable low, together with a clear, and together with a disarm, which checks each priority rule. Last, the bench switches legacy mode and then places two timers on one line, which separates fixed routes from configured ones and shows the OR merge.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
    // Per-timer interrupt state: held level bit and one-cycle pulse
    typedef struct packed {
        logic status;
        logic pulse;
    } slot_state_t;
endpackage

// File: rtl/tirq_slot.sv
module tirq_slot
    import tirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic disarm_i,
    input  logic armed_i,
    input  logic level_i,
    input  logic clr_i,
    output logic status_o,
    output logic pulse_o
);
    slot_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (disarm_i) begin
            st_d.status = 1'b0;
        end else if (fire_i) begin
            if (!armed_i) begin
                st_d.status = 1'b0;
            end else if (level_i) begin
                st_d.status = 1'b1;
            end else begin
                st_d.status = 1'b0;
                st_d.pulse  = 1'b1;
            end
        end else if (clr_i) begin
            st_d.status = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o = st_q.status;
    assign pulse_o  = st_q.pulse;
endmodule

// File: rtl/tirq_route_sel.sv
module tirq_route_sel #(
    parameter int NT     = 3,
    parameter int RW     = 5,
    parameter int LEG_R0 = 2,
    parameter int LEG_R1 = 8
) (
    input  logic             legacy_i,
    input  logic [NT*RW-1:0] cfg_route_i,
    output logic [NT*RW-1:0] eff_route_o
);
    for (genvar i = 0; i < NT; i++) begin : g_sel
        if (i == 0) begin : g_leg0
            assign eff_route_o[i*RW +: RW] = legacy_i ? RW'(LEG_R0) : cfg_route_i[i*RW +: RW];
        end else if (i == 1) begin : g_leg1
            assign eff_route_o[i*RW +: RW] = legacy_i ? RW'(LEG_R1) : cfg_route_i[i*RW +: RW];
        end else begin : g_cfg
            assign eff_route_o[i*RW +: RW] = cfg_route_i[i*RW +: RW];
        end
    end
endmodule

// File: rtl/tirq_line_merge.sv
module tirq_line_merge #(
    parameter int NT = 3,
    parameter int NL = 32,
    parameter int RW = 5
) (
    input  logic [NT-1:0]    active_i,
    input  logic [NT*RW-1:0] route_i,
    output logic [NL-1:0]    lines_o
);
    always_comb begin
        lines_o = '0;
        for (int l = 0; l < NL; l++) begin
            for (int i = 0; i < NT; i++) begin
                if (active_i[i] && (route_i[i*RW +: RW] == RW'(l))) lines_o[l] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tirq_status_router.sv
module tirq_status_router #(
    parameter int NT     = 3,
    parameter int NL     = 32,
    parameter int SW     = 32,
    parameter int LEG_R0 = 2,
    parameter int LEG_R1 = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        glb_enable,
    input  logic                        legacy_mode,
    input  logic [NT-1:0]               tmr_enable,
    input  logic [NT-1:0]               tmr_level,
    input  logic [NT*$clog2(NL)-1:0]    tmr_route,
    input  logic [NT-1:0]               fire,
    input  logic [NT-1:0]               disarm,
    input  logic                        sts_wr,
    input  logic [SW-1:0]               sts_wdata,
    output logic [SW-1:0]               sts_rdata,
    output logic [NL-1:0]               irq_lines
);
    localparam int RW = $clog2(NL);

    logic [NT-1:0]    status_w;
    logic [NT-1:0]    pulse_w;
    logic [NT*RW-1:0] eff_route_w;

    for (genvar i = 0; i < NT; i++) begin : g_slot
        tirq_slot i_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .fire_i   (fire[i]),
            .disarm_i (disarm[i]),
            .armed_i  (tmr_enable[i] & glb_enable),
            .level_i  (tmr_level[i]),
            .clr_i    (sts_wr & sts_wdata[i]),
            .status_o (status_w[i]),
            .pulse_o  (pulse_w[i])
        );
    end

    tirq_route_sel #(.NT(NT), .RW(RW), .LEG_R0(LEG_R0), .LEG_R1(LEG_R1)) i_route (
        .legacy_i    (legacy_mode),
        .cfg_route_i (tmr_route),
        .eff_route_o (eff_route_w)
    );

    tirq_line_merge #(.NT(NT), .NL(NL), .RW(RW)) i_merge (
        .active_i (status_w | pulse_w),
        .route_i  (eff_route_w),
        .lines_o  (irq_lines)
    );

    assign sts_rdata = SW'(status_w);
endmodule

// File: rtl/tirq_checker.sv
module tirq_checker #(
    parameter int NT     = 3,
    parameter int NL     = 32,
    parameter int SW     = 32,
    parameter int LEG_R0 = 2,
    parameter int LEG_R1 = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     glb_enable,
    input logic                     legacy_mode,
    input logic [NT-1:0]            tmr_enable,
    input logic [NT-1:0]            tmr_level,
    input logic [NT*$clog2(NL)-1:0] tmr_route,
    input logic [NT-1:0]            fire,
    input logic [NT-1:0]            disarm,
    input logic                     sts_wr,
    input logic [SW-1:0]            sts_wdata,
    input logic [SW-1:0]            sts_rdata,
    input logic [NL-1:0]            irq_lines
);
    localparam int RW = $clog2(NL);

    for (genvar i = 0; i < NT; i++) begin : g_chk
        logic [RW-1:0] rt;
        assign rt = (legacy_mode && i == 0) ? RW'(LEG_R0) :
                    (legacy_mode && i == 1) ? RW'(LEG_R1) : tmr_route[i*RW +: RW];

        // R2
        level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && !disarm[i] && tmr_enable[i] && glb_enable && tmr_level[i] |=> sts_rdata[i]);
        // R3
        edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && !tmr_level[i] |=> !sts_rdata[i]);
        // R4
        disabled_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
            fire[i] && !(tmr_enable[i] && glb_enable) |=> !sts_rdata[i]);
        // R5
        w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sts_wr && sts_wdata[i] && !fire[i] |=> !sts_rdata[i]);
        // R7
        disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            disarm[i] |=> !sts_rdata[i]);
        // R10
        hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !fire[i] && !disarm[i] && !(sts_wr && sts_wdata[i]) |=> $stable(sts_rdata[i]));
        // R2
        line_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sts_rdata[i] |-> irq_lines[rt]);
    end

    // R1
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_rdata[SW-1:NT] == '0);
endmodule

bind tirq_status_router tirq_checker #(
    .NT(NT), .NL(NL), .SW(SW), .LEG_R0(LEG_R0), .LEG_R1(LEG_R1)
) i_tirq_checker (
    .clk(clk), .rst_n(rst_n), .glb_enable(glb_enable), .legacy_mode(legacy_mode),
    .tmr_enable(tmr_enable), .tmr_level(tmr_level), .tmr_route(tmr_route),
    .fire(fire), .disarm(disarm), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
    .sts_rdata(sts_rdata), .irq_lines(irq_lines)
);

// File: tb/test_tirq_status_router.sv
module test_tirq_status_router;
    localparam int NT = 3;
    localparam int NL = 32;
    localparam int RW = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic glb_enable = 1'b0, legacy_mode = 1'b0;
    logic [NT-1:0] tmr_enable = '0, tmr_level = '0, fire = '0, disarm = '0;
    logic [NT*RW-1:0] tmr_route = '0;
    logic sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic [31:0] sts_rdata;
    logic [NL-1:0] irq_lines;

    always #5 clk = ~clk;

    tirq_status_router i_tirq_status_router (
        .clk(clk), .rst_n(rst_n), .glb_enable(glb_enable), .legacy_mode(legacy_mode),
        .tmr_enable(tmr_enable), .tmr_level(tmr_level), .tmr_route(tmr_route),
        .fire(fire), .disarm(disarm), .sts_wr(sts_wr), .sts_wdata(sts_wdata),
        .sts_rdata(sts_rdata), .irq_lines(irq_lines)
    );

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    // pending configuration applied by the driver
    logic c_glb = 1'b1, c_leg = 1'b0;
    logic [NT-1:0] c_en = '1, c_lvl = '0;
    logic [RW-1:0] c_rt [NT];

    // reference model state
    logic [NT-1:0] m_st = '0, m_pl = '0;

    logic [31:0] exp_st_q [$];
    logic [31:0] exp_ln_q [$];
    string       tag_q    [$];

    function automatic logic [RW-1:0] eff_rt(int i);
        if (c_leg && i == 0) return RW'(2);
        if (c_leg && i == 1) return RW'(8);
        return c_rt[i];
    endfunction

    task automatic step(input logic [NT-1:0] f, input logic [NT-1:0] d,
                        input logic w, input logic [31:0] wd, input string tag);
        logic [31:0] el;
        @(posedge clk); #2;
        glb_enable = c_glb; legacy_mode = c_leg; tmr_enable = c_en; tmr_level = c_lvl;
        for (int i = 0; i < NT; i++) tmr_route[i*RW +: RW] = c_rt[i];
        fire = f; disarm = d; sts_wr = w; sts_wdata = wd;
        for (int i = 0; i < NT; i++) begin
            m_pl[i] = 1'b0;
            if (d[i]) m_st[i] = 1'b0;
            else if (f[i]) begin
                if (!(c_en[i] && c_glb)) m_st[i] = 1'b0;
                else if (c_lvl[i]) m_st[i] = 1'b1;
                else begin m_st[i] = 1'b0; m_pl[i] = 1'b1; end
            end else if (w && wd[i]) m_st[i] = 1'b0;
        end
        el = '0;
        for (int i = 0; i < NT; i++) if (m_st[i] || m_pl[i]) el[eff_rt(i)] = 1'b1;
        exp_st_q.push_back(32'(m_st));
        exp_ln_q.push_back(el);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input string tag);
        step('0, '0, 1'b0, '0, tag);
    endtask

    // monitor: compares one result per clock, just after the edge
    initial begin
        forever begin
            @(posedge clk); #1;
            if (exp_st_q.size() > 0) begin
                logic [31:0] es, el;
                string t;
                es = exp_st_q.pop_front(); el = exp_ln_q.pop_front(); t = tag_q.pop_front();
                n_run++;
                if (sts_rdata !== es || irq_lines !== el) begin
                    n_fail++;
                    $display("FAIL %s: status=%h lines=%h expected status=%h lines=%h",
                             t, sts_rdata, irq_lines, es, el);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        c_rt[0] = 5'd3; c_rt[1] = 5'd4; c_rt[2] = 5'd5;
        repeat (3) @(posedge clk);
        #1;
        n_run++;
        if (sts_rdata !== '0 || irq_lines !== '0) begin
            n_fail++;
            $display("FAIL R1 reset: status=%h lines=%h expected 0 0", sts_rdata, irq_lines);
        end
        @(negedge clk); rst_n = 1'b1;

        // R2 level fire on timer 0, held
        c_lvl = 3'b001;
        step(3'b001, '0, 0, '0, "R2 level fire");
        idle("R2 hold 1"); idle("R10 hold 2");
        // R3 edge pulse on timer 1 for one cycle
        step(3'b010, '0, 0, '0, "R3 edge fire");
        idle("R3 pulse ends");
        // R5 zero writes, non-matching, matching
        step('0, '0, 1, 32'h0, "R5 zero write");
        step('0, '0, 1, 32'h2, "R5 other bit");
        step('0, '0, 1, 32'h1, "R5 clear t0");
        // R6 fire beats clear
        step(3'b001, '0, 1, 32'h1, "R6 fire vs clear");
        // R7 disarm clears, and beats fire
        step('0, 3'b001, 0, '0, "R7 disarm");
        step(3'b001, 3'b001, 0, '0, "R7 disarm vs fire");
        // R4 global and timer enable
        step(3'b001, '0, 0, '0, "R4 set again");
        c_glb = 1'b0;
        step(3'b001, '0, 0, '0, "R4 global off");
        step(3'b010, '0, 0, '0, "R4 global off edge");
        c_glb = 1'b1; c_en = 3'b110;
        step(3'b001, '0, 0, '0, "R4 timer off");
        c_en = 3'b111;
        // R1 bit mapping with all three levels
        c_lvl = 3'b111;
        step(3'b111, '0, 0, '0, "R1 all set");
        step('0, '0, 1, 32'hFFFF_FFFF, "R5 R1 clear all");
        // R8 legacy routes
        c_leg = 1'b1; c_lvl = 3'b101;
        step(3'b101, '0, 0, '0, "R8 legacy level");
        step(3'b010, '0, 0, '0, "R8 legacy edge");
        idle("R8 legacy hold");
        c_leg = 1'b0;
        idle("R8 legacy off");
        step('0, '0, 1, 32'h5, "R5 clear");
        // R9 shared line
        c_rt[1] = 5'd6; c_rt[2] = 5'd6; c_lvl = 3'b100;
        step(3'b110, '0, 0, '0, "R9 shared fire");
        idle("R9 shared hold");
        step(3'b010, '0, 1, 32'h4, "R9 pulse only");
        idle("R9 line low");
        // R3 edge fire clears a held bit
        c_lvl = 3'b100;
        step(3'b100, '0, 0, '0, "R2 set t2");
        c_lvl = 3'b000;
        step(3'b100, '0, 0, '0, "R3 edge clears bit");
        idle("R3 drained");
        @(posedge clk); #3;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule